// File: doc/BRIEF.md
# Wake-up Line Aggregator

This block gathers a set of asynchronous wake-up lines into one edge-sensitive interrupt channel. Each line passes through a synchroniser and a rising-edge detector. A detected edge latches a pending bit owned by that line. The pending bits that are enabled by a per-line mask are ORed into a single combined line. A rising edge on the combined line sets a channel pending flag, and a channel enable gates that flag onto the request output.

An edge-sensitive channel has a known weakness. While the combined line is already high, a later event on another line adds a pending bit but produces no new edge. To handle this, the block watches every software write that clears pending bits. If such a write leaves at least one enabled bit pending, the block pulls the combined line low for one clock. The line then rises again and sets the channel flag once more. If software clears every pending bit, the line simply falls and no request follows.

Software reaches the state through a small byte-wide register port:

| Address | Contents |
|---|---|
| 0 | Pending bits for lines 0 to 7 |
| 1 | Pending bits for lines 8 to 15 |
| 2 | Line mask for lines 0 to 7 |
| 3 | Line mask for lines 8 to 15 |
| 4 | Channel control: bit 0 is the channel flag, bit 1 is the channel enable |

Top module: `wul_aggregator`

## Requirements
- R1: A rising edge on any line sets that line's pending bit, with several lines rising together all latched. The bit becomes visible on the third rising clock edge after the input rises (two synchroniser stages plus the edge register).
- R2: The combined line is high when any pending bit is set whose line-mask bit is 1. A rising edge of the combined line sets the channel flag (control register bit 0) at the next clock edge.
- R3: While the combined line stays high, a new line event sets its pending bit but does not set the channel flag again.
- R4: A pending-byte write that leaves one or more enabled bits pending drives the combined line low for exactly the one clock that follows the write edge. The line then rises once, which sets the channel flag again.
- R5: The channel request output equals the channel flag ANDed with the channel enable (control register bit 1).
- R6: A write to address 0 (lines 0 to 7) or address 1 (lines 8 to 15) clears each pending bit whose written bit is 0, keeps each bit whose written bit is 1, and leaves the other byte unchanged.
- R7: A write that clears the last pending bit produces no rising edge and no request. If the channel enable is cleared first, the channel request output stays low for the whole clearing sequence.
- R8: A line-mask bit (address 2 for lines 0 to 7, address 3 for lines 8 to 15, 1 = included) of 0 keeps that line out of the combined line. Its pending bit is still set and still reads back.
- R9: When a line edge and a pending-byte write that clears the same bit fall in the same cycle, the bit ends up set.
- R10: Writing 0 to control bit 0 clears the channel flag, but a combined-line rising edge in the same cycle leaves the flag set.
- R11: After reset all registers read zero, and the combined line and the channel request output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 16 | Asynchronous wake-up lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| combLine | output | 1 | Combined line of enabled pending bits, including the re-edge gap |
| chanReq | output | 1 | Channel interrupt request |

## Verification
The bench builds the block with its default two byte halves and two synchroniser stages. The two halves make it possible to clear one byte while the other keeps enabled bits pending, which exercises the re-edge path. The fixed three-clock edge latency lets the bench place a line edge and a software clear in the same cycle, both for a pending bit and for the channel flag, and so check both priority rules.

// File: rtl/wul_pkg.sv
package wul_pkg;
  parameter int unsigned WUL_BYTES = 2;

  // Strobes issued by the control to the datapath in one cycle
  typedef struct packed {
    logic [WUL_BYTES-1:0] pendWr;  // clear-by-zero write per pending byte
    logic [WUL_BYTES-1:0] maskWr;  // load per line-mask byte
    logic [7:0]           data;    // write data shared by all strobes
  } wul_strobe_t;
endpackage

// File: rtl/wul_datapath.sv
module wul_datapath
  import wul_pkg::*;
#(
  parameter int unsigned LINES       = 16,
  parameter int unsigned BYTES       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] lineIn,
  input  wul_strobe_t      strb,
  output logic [LINES-1:0] pendVec,
  output logic [LINES-1:0] lineMask,
  output logic             armedAny,
  output logic             keepArmed
);
  logic [LINES-1:0] lineLvl;
  logic [LINES-1:0] linePrev;
  logic [LINES-1:0] lineEdge;
  logic [LINES-1:0] clrKeep;
  logic [LINES-1:0] pendNext;

  for (genvar i = 0; i < LINES; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg <= '0;
      else       shReg <= {shReg[SYNC_STAGES-2:0], lineIn[i]};
    end
    assign lineLvl[i] = shReg[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '0;
    else       linePrev <= lineLvl;
  end

  assign lineEdge = lineLvl & ~linePrev;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign clrKeep[b*8 +: 8] = strb.pendWr[b] ? strb.data : 8'hFF;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               lineMask[b*8 +: 8] <= '0;
      else if (strb.maskWr[b]) lineMask[b*8 +: 8] <= strb.data;
    end
  end

  // A fresh edge is ORed in after the clear, so setting wins
  assign pendNext = (pendVec & clrKeep) | lineEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendVec <= '0;
    else       pendVec <= pendNext;
  end

  assign armedAny  = |(pendVec & lineMask);
  assign keepArmed = |(pendNext & lineMask);
endmodule

// File: rtl/wul_control.sv
module wul_control
  import wul_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic [LINES-1:0]  pendVec,
  input  logic [LINES-1:0]  lineMask,
  input  logic              armedAny,
  input  logic              keepArmed,
  output wul_strobe_t       strb,
  output logic              combLine,
  output logic              chanPend,
  output logic              chanEn,
  output logic [7:0]        regRdData
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * BYTES);

  logic ctrlWr;
  logic gapQ;
  logic combPrev;
  logic chanRise;

  always_comb begin
    strb.data = regWrData;
    for (int b = 0; b < BYTES; b++) begin
      strb.pendWr[b] = regWrEn && (regAddr == ADDR_W'(b));
      strb.maskWr[b] = regWrEn && (regAddr == ADDR_W'(BYTES + b));
    end
  end

  assign ctrlWr = regWrEn && (regAddr == CTRL_ADDR);

  // One-clock gap after a clear that leaves enabled bits pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapQ <= 1'b0;
    else       gapQ <= (|strb.pendWr) && keepArmed;
  end

  assign combLine = armedAny && !gapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) combPrev <= 1'b0;
    else       combPrev <= combLine;
  end

  assign chanRise = combLine && !combPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanPend <= 1'b0;
      chanEn   <= 1'b0;
    end else begin
      if (chanRise)                      chanPend <= 1'b1;
      else if (ctrlWr && !regWrData[0])  chanPend <= 1'b0;
      if (ctrlWr)                        chanEn   <= regWrData[1];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < BYTES; b++) begin
      if (regAddr == ADDR_W'(b))         regRdData = pendVec[b*8 +: 8];
      if (regAddr == ADDR_W'(BYTES + b)) regRdData = lineMask[b*8 +: 8];
    end
    if (regAddr == CTRL_ADDR) regRdData = {6'b0, chanEn, chanPend};
  end
endmodule

// File: rtl/wul_aggregator.sv
module wul_aggregator
  import wul_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [8*WUL_BYTES-1:0] lineIn,
  input  logic                   regWrEn,
  input  logic [2:0]             regAddr,
  input  logic [7:0]             regWrData,
  output logic [7:0]             regRdData,
  output logic                   combLine,
  output logic                   chanReq
);
  localparam int unsigned BYTES  = WUL_BYTES;
  localparam int unsigned LINES  = 8 * BYTES;
  localparam int unsigned ADDR_W = 3;

  wul_strobe_t      strb;
  logic [LINES-1:0] pendVec;
  logic [LINES-1:0] lineMask;
  logic             armedAny;
  logic             keepArmed;
  logic             chanPend;
  logic             chanEn;

  wul_datapath #(.LINES(LINES), .BYTES(BYTES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .strb(strb),
    .pendVec(pendVec), .lineMask(lineMask),
    .armedAny(armedAny), .keepArmed(keepArmed)
  );

  wul_control #(.LINES(LINES), .BYTES(BYTES), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .pendVec(pendVec), .lineMask(lineMask),
    .armedAny(armedAny), .keepArmed(keepArmed), .strb(strb),
    .combLine(combLine), .chanPend(chanPend), .chanEn(chanEn),
    .regRdData(regRdData)
  );

  assign chanReq = chanPend && chanEn;
endmodule

// File: rtl/wul_checker.sv
module wul_checker
  import wul_pkg::*;
#(
  parameter int unsigned LINES = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             combLine,
  input logic             chanPend,
  input logic [LINES-1:0] pendVec,
  input logic             keepArmed,
  input wul_strobe_t      strb
);
  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(combLine) |=> chanPend); // R2

  AST_FLAG_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chanPend) |-> ($past(combLine) && !$past(combLine, 2))); // R3

  AST_REEDGE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ((|strb.pendWr) && keepArmed) |=> !combLine); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(|strb.pendWr) |=> ((pendVec & $past(pendVec)) == $past(pendVec))); // R6
endmodule

bind wul_aggregator wul_checker #(.LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .combLine(combLine), .chanPend(chanPend),
  .pendVec(pendVec), .keepArmed(keepArmed), .strb(strb)
);

// File: tb/test_wul_aggregator.sv
`timescale 1ns/1ps
module test_wul_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] lineIn = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        combLine;
  logic        chanReq;

  int checks = 0;
  int fails = 0;
  int riseCnt = 0;
  bit lastComb = 0;
  bit watchReq = 0;
  bit reqSeen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wul_aggregator i_wul_aggregator (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .combLine(combLine), .chanReq(chanReq)
  );

  always @(negedge clk) begin
    if (combLine && !lastComb) riseCnt++;
    lastComb = combLine;
    if (watchReq && chanReq) reqSeen = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseLines(input logic [15:0] m);
    @(negedge clk);
    lineIn = lineIn | m;
    waitCyc(6);
    lineIn = lineIn & ~m;
    waitCyc(4);
  endtask

  task automatic testReset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      chk("R11 register reset value", v, 8'h00);
    end
    chk("R11 combLine after reset", combLine, 1'b0);
    chk("R11 chanReq after reset", chanReq, 1'b0);
  endtask

  task automatic testSimultaneous();
    logic [7:0] v;
    regWrite(3'd2, 8'hFF);
    regWrite(3'd3, 8'hFF);
    regWrite(3'd4, 8'h02);
    pulseLines(16'h8221);
    regRead(3'd0, v); chk("R1 low byte pending", v, 8'h21);
    regRead(3'd1, v); chk("R1 high byte pending", v, 8'h82);
    regRead(3'd4, v); chk("R2 channel flag set", v, 8'h03);
    chk("R5 request with enable", chanReq, 1'b1);
  endtask

  task automatic testNoNewEdge();
    logic [7:0] v;
    regWrite(3'd4, 8'h02);
    pulseLines(16'h0008);
    regRead(3'd0, v); chk("R3 new pending bit latched", v, 8'h29);
    regRead(3'd4, v); chk("R3 flag not set again", v, 8'h02);
    chk("R3 combLine still high", combLine, 1'b1);
  endtask

  task automatic testPartialClear();
    logic [7:0] v;
    riseCnt = 0;
    regWrite(3'd0, 8'hFE);
    chk("R4 combLine low in gap cycle", combLine, 1'b0);
    @(negedge clk);
    chk("R4 combLine high after gap", combLine, 1'b1);
    waitCyc(3);
    chk("R4 exactly one new rise", riseCnt, 1);
    regRead(3'd4, v); chk("R4 flag set again", v, 8'h03);
    regRead(3'd0, v); chk("R6 low byte partially cleared", v, 8'h28);
    regRead(3'd1, v); chk("R6 high byte untouched", v, 8'h82);
  endtask

  task automatic testFullClear();
    logic [7:0] v;
    regWrite(3'd4, 8'h00);
    reqSeen = 0; watchReq = 1;
    regWrite(3'd1, 8'h00);
    waitCyc(4);
    regWrite(3'd4, 8'h00);
    riseCnt = 0;
    regWrite(3'd0, 8'h00);
    waitCyc(6);
    watchReq = 0;
    chk("R7 no rise after full clear", riseCnt, 0);
    chk("R7 combLine low", combLine, 1'b0);
    chk("R7 no request during sequence", reqSeen, 1'b0);
    regRead(3'd4, v); chk("R7 control cleared", v, 8'h00);
    regWrite(3'd4, 8'h02);
    waitCyc(3);
    chk("R7 no request after re-enable", chanReq, 1'b0);
  endtask

  task automatic testChanMask();
    logic [7:0] v;
    regWrite(3'd4, 8'h00);
    pulseLines(16'h0002);
    regRead(3'd4, v); chk("R5 flag set while disabled", v, 8'h01);
    chk("R5 request blocked when disabled", chanReq, 1'b0);
    regWrite(3'd4, 8'h03);
    chk("R5 request after enable", chanReq, 1'b1);
    regWrite(3'd0, 8'h00);
    regWrite(3'd4, 8'h02);
    chk("R10 write zero clears flag", chanReq, 1'b0);
  endtask

  task automatic testLineMask();
    logic [7:0] v;
    regWrite(3'd3, 8'h00);
    pulseLines(16'h1000);
    regRead(3'd1, v); chk("R8 masked line pending readable", v, 8'h10);
    chk("R8 masked line keeps combLine low", combLine, 1'b0);
    regRead(3'd4, v); chk("R8 flag not set by masked line", v, 8'h02);
    regWrite(3'd1, 8'h00);
    regWrite(3'd3, 8'hFF);
  endtask

  task automatic testSetBeatsClear();
    logic [7:0] v;
    @(negedge clk);
    lineIn[6] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    regWrite(3'd0, 8'h00);
    regRead(3'd0, v); chk("R9 edge beats pending clear", v, 8'h40);
    lineIn[6] = 1'b0;
    waitCyc(5);
    regWrite(3'd0, 8'h00);
    regWrite(3'd4, 8'h02);
    regRead(3'd0, v); chk("R6 pending cleared by zero write", v, 8'h00);
  endtask

  task automatic testFlagPriority();
    logic [7:0] v;
    @(negedge clk);
    lineIn[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    regWrite(3'd4, 8'h02);
    regRead(3'd4, v); chk("R10 rise beats flag clear", v, 8'h03);
    chk("R10 request present", chanReq, 1'b1);
    lineIn[2] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSimultaneous();
    testNoNewEdge();
    testPartialClear();
    testFullClear();
    testChanMask();
    testLineMask();
    testSetBeatsClear();
    testFlagPriority();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule